// File: doc/BRIEF.md
# Serial Register Access Engine

This block performs register reads and writes on a serial peripheral attached by SPI, such as a frequency synthesizer that is configured over a four-wire bus. A host presents one command in a single cycle: direction, a 13-bit register address, a byte count from 1 to 4, write data and the encoded select value of the target device. The engine then forms a 16-bit instruction word and shifts it out, most significant bit first. The data bytes follow directly, and the whole transfer happens inside one select assertion.

For reads, the engine clocks in exactly the requested number of bytes and returns them zero-extended in a 32-bit result. A streaming mode sends one instruction followed by a fixed run of eight data bytes. Illegal commands raise a one-cycle error pulse and produce no bus activity. A one-cycle completion pulse ends every accepted transfer, and any read result is valid in that same cycle.

Top module: `spi_reg_engine`

## Requirements
- R1: The instruction word is shifted out first, MSB first, as {read flag, length code[1:0], address[12:0]}. The read flag is 1 for a read and 0 for a write. The length code is the byte count minus one for a single access and 3 for a streaming write.
- R2: On a single write of N bytes, the low N bytes of `cmd_wdata[31:0]` follow the instruction with the most significant used byte first, so the transfer is exactly 16+8N bits. On a read, MOSI carries zeros after the instruction.
- R3: On a read of N bytes, `rdata` holds the last 8N bits sampled from MISO, right-aligned, with bits 31:8N cleared. After a write, `rdata` is 0.
- R4: A single access whose `cmd_len` is not in 1..4 is rejected: `err` pulses for one cycle in the cycle after the command, `busy` stays low and SCLK never toggles.
- R5: The select value `cmd_cs` must lie in 4..7, otherwise the command is rejected as in R4. During an accepted transfer `cs_code` equals `cmd_cs` from the first instruction bit to the last data bit. It is 0 when idle.
- R6: With `cmd_stream` set, the length code is 3 and all 64 bits of `cmd_wdata` follow the instruction MSB first, giving 80 bits under one select assertion. `cmd_len` is ignored. A streaming command with `cmd_read` set is rejected.
- R7: SCLK is the system clock divided by 4. It is low while idle and low for the first two cycles of each bit. MOSI changes only on a falling SCLK edge, and MISO is sampled at the rising edge.
- R8: A command is accepted only while `busy` is low. A `cmd_valid` during a transfer has no effect on the bits sent or on the select value.
- R9: For a transfer of B bits accepted at clock edge E, `done` is high for exactly one cycle, following edge E+4B. In that same cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_stream | input | 1 | Streaming write of eight bytes |
| cmd_addr | input | 13 | Register address |
| cmd_len | input | 3 | Byte count of a single access (1..4) |
| cmd_cs | input | 3 | Encoded device select (4..7) |
| cmd_wdata | input | 64 | Write data; low 32 bits for single writes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rdata | output | 32 | Masked read result, valid with done |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_code | output | 3 | Encoded select, 0 when idle |

## Verification
A command accepted at edge E produces a rejection pulse, or a busy flag together with the select value, right after E. Its completion pulse and read result appear right after edge E+4B, where B is 16 plus eight times the byte count, or 80 when streaming. The bench counts falling clock edges from the command. It checks `err`/`busy`/`cs_code` on the first count, checks the SCLK level on each count against the divide-by-4 phase, and requires `done` to arrive on count 4B+1 exactly. A behavioural device model records MOSI on rising SCLK edges and drives MISO on falling ones, so the frame content and the masked read data are compared with values the bench computes from the command.

// File: rtl/spi_reg_engine.sv
module spi_reg_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic        cmd_stream,
  input  logic [12:0] cmd_addr,
  input  logic [2:0]  cmd_len,
  input  logic [2:0]  cmd_cs,
  input  logic [63:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [2:0]  cs_code
);
  localparam int FRAME_W = 80;

  logic [FRAME_W-1:0] sh;
  logic [6:0]  bits_left;
  logic [1:0]  ph;
  logic [31:0] rx;
  logic [2:0]  len_q;
  logic        rd_q;
  logic        active;
  logic [2:0]  cs_q;

  wire        take   = cmd_valid && !active;
  wire        len_ok = (cmd_len >= 3'd1) && (cmd_len <= 3'd4);
  wire        legal  = cmd_cs[2] && (cmd_stream ? !cmd_read : len_ok);
  wire        is_rd  = cmd_read && !cmd_stream;
  wire [1:0]  lcode  = cmd_stream ? 2'd3 : 2'(cmd_len - 3'd1);
  wire [15:0] instr  = {is_rd, lcode, cmd_addr};
  wire [5:0]  pad    = 6'd32 - {cmd_len, 3'b000};
  wire [31:0] wjust  = cmd_wdata[31:0] << pad;
  wire [63:0] payload = cmd_stream ? cmd_wdata : (is_rd ? 64'd0 : {wjust, 32'd0});
  wire [6:0]  nbits  = cmd_stream ? 7'd80 : 7'd16 + {1'b0, cmd_len, 3'b000};
  wire [31:0] mask   = (len_q == 3'd4) ? 32'hFFFF_FFFF
                                       : ((32'd1 << {len_q, 3'b000}) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; bits_left <= '0; ph <= '0; rx <= '0; len_q <= '0;
      rd_q <= 1'b0; active <= 1'b0; cs_q <= '0;
      done <= 1'b0; err <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (take) begin
        if (legal) begin
          active    <= 1'b1;
          sh        <= {instr, payload};
          bits_left <= nbits;
          ph        <= 2'd0;
          cs_q      <= cmd_cs;
          rd_q      <= is_rd;
          len_q     <= cmd_len;
          rx        <= '0;
        end else begin
          err <= 1'b1;
        end
      end else if (active) begin
        ph <= ph + 2'd1;
        if (ph == 2'd1) rx <= {rx[30:0], miso};
        if (ph == 2'd3) begin
          sh        <= sh << 1;
          bits_left <= bits_left - 7'd1;
          if (bits_left == 7'd1) begin
            active <= 1'b0;
            cs_q   <= '0;
            done   <= 1'b1;
            rdata  <= rd_q ? (rx & mask) : 32'd0;
          end
        end
      end
    end
  end

  assign busy    = active;
  assign sclk    = active && ph[1];
  assign mosi    = active && sh[FRAME_W-1];
  assign cs_code = cs_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy && !sclk)); // R4
  AST_CS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cs_code[2]); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (cs_code == 3'd0 && !sclk)); // R7
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (!busy || $stable(cs_code))); // R8
  AST_MOSI_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && sclk) |=> (!sclk || $stable(mosi))); // R7
  AST_MOSI_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && $rose(sclk)) |-> $stable(mosi)); // R7
endmodule

// File: tb/spi_reg_engine_tb_top.sv
module spi_reg_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_stream = 1'b0;
  logic [12:0] cmd_addr = '0;
  logic [2:0]  cmd_len = '0, cmd_cs = '0;
  logic [63:0] cmd_wdata = '0;
  logic busy, done, err, sclk, mosi;
  logic miso = 1'b1;
  logic [31:0] rdata;
  logic [2:0]  cs_code;
  int n_chk = 0, n_bad = 0;
  logic [79:0] cap;
  int scnt;

  always #5 clk = ~clk;

  spi_reg_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_stream(cmd_stream), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_cs(cmd_cs), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_code(cs_code));

  function automatic logic [31:0] dev_word(input logic [12:0] a);
    return {a[7:0] ^ 8'hA5, a[12:5], a[7:0] ^ 8'h3C, a[7:0] + 8'd1};
  endfunction

  always @(posedge sclk) begin
    cap = {cap[78:0], mosi};
    scnt = scnt + 1;
  end

  always @(negedge sclk) begin
    logic [15:0] ins;
    int j, nb;
    miso = 1'b1;
    if (scnt >= 16 && scnt <= 80) begin
      ins = cap[scnt-1 -: 16];
      nb = int'(ins[14:13]) + 1;
      j = scnt - 16;
      if (ins[15] && j < 8*nb) miso = dev_word(ins[12:0])[8*nb-1-j];
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic rd, input logic st, input logic [12:0] a, input logic [2:0] len,
                     input logic [2:0] cs, input logic [63:0] wd, input logic ok, input logic stray,
                     input string rtag);
    int cyc, nb, B, sbad;
    logic [15:0] ins;
    logic [63:0] pay;
    logic [79:0] frame;
    logic [31:0] mk, exp_rd;
    @(negedge clk);
    cap = '0; scnt = 0;
    cmd_valid = 1'b1; cmd_read = rd; cmd_stream = st; cmd_addr = a;
    cmd_len = len; cmd_cs = cs; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    if (!ok) begin
      chk(err === 1'b1 && busy === 1'b0, {rtag, " reject err pulse"}, {78'd0, err, busy}, 80'd2);
      repeat (4) @(negedge clk);
      chk(scnt == 0 && cs_code == 3'd0 && err === 1'b0, {rtag, " reject no bus activity"}, 80'(scnt), 80'd0);
      return;
    end
    chk(busy === 1'b1 && cs_code == cs, "R5 select driven", {77'd0, cs_code}, {77'd0, cs});
    nb = st ? 8 : int'(len);
    B = 16 + 8*nb;
    sbad = 0;
    while (done !== 1'b1 && cyc < 1000) begin
      if (sclk !== (((cyc-1) % 4) >= 2)) sbad++;
      if (busy && cs_code != cs) sbad++;
      @(negedge clk);
      cyc++;
      if (stray && cyc == 10) begin
        cmd_valid = 1'b1; cmd_addr = ~a; cmd_read = ~rd; cmd_cs = 3'd7 - cs + 3'd4;
      end
      if (stray && cyc == 11) cmd_valid = 1'b0;
    end
    chk(sbad == 0, "R7 sclk divide-by-4 and R5 select held", 80'(sbad), 80'd0);
    chk(cyc == 4*B + 1, "R9 done timing", 80'(cyc), 80'(4*B + 1));
    chk(busy === 1'b0, "R9 busy low with done", {79'd0, busy}, 80'd0);
    ins = {rd & ~st, st ? 2'd3 : 2'(len - 3'd1), a};
    chk(scnt == B, {rtag, " bit count"}, 80'(scnt), 80'(B));
    chk(cap[B-1 -: 16] == ins, "R1 instruction word", {64'd0, cap[B-1 -: 16]}, {64'd0, ins});
    if (st) pay = wd;
    else if (rd) pay = 64'd0;
    else pay = {wd[31:0] << (32 - 8*nb), 32'd0};
    frame = {ins, pay};
    chk(cap == (frame >> (80 - B)), {rtag, " frame content"}, cap, frame >> (80 - B));
    mk = (nb >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nb)) - 32'd1);
    exp_rd = (rd && !st) ? (dev_word(a) & mk) : 32'd0;
    chk(rdata == exp_rd, "R3 read data", {48'd0, rdata}, {48'd0, exp_rd});
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", {79'd0, done}, 80'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    cap = '0; scnt = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && sclk === 1'b0 && cs_code == 3'd0 && rdata == 32'd0,
        "R5 reset state", {46'd0, rdata, busy, done, err, sclk}, 80'd0);
    rst_n = 1'b1;
    run(1'b0, 1'b0, 13'h0123, 3'd0, 3'd4, 64'hAB, 1'b0, 1'b0, "R4 len 0");
    run(1'b1, 1'b0, 13'h0456, 3'd5, 3'd5, 64'h0, 1'b0, 1'b0, "R4 len 5");
    run(1'b0, 1'b0, 13'h0010, 3'd2, 3'd3, 64'h1234, 1'b0, 1'b0, "R5 cs 3");
    run(1'b0, 1'b0, 13'h0010, 3'd2, 3'd0, 64'h1234, 1'b0, 1'b0, "R5 cs 0");
    run(1'b1, 1'b1, 13'h0020, 3'd1, 3'd6, 64'h0, 1'b0, 1'b0, "R6 stream read");
    for (int l = 1; l <= 4; l++)
      run(1'b1, 1'b0, 13'(16'h1A0 + l), 3'(l), 3'(3 + l), 64'h0, 1'b1, 1'b0, "R3 read len");
    run(1'b0, 1'b0, 13'h1FFF, 3'd1, 3'd4, 64'hFFFF_FFFF_FFFF_FF5A, 1'b1, 1'b0, "R2 write len1");
    run(1'b0, 1'b0, 13'h01AB, 3'd4, 3'd7, 64'h0000_0000_DEAD_BEEF, 1'b1, 1'b1, "R8 stray cmd");
    run(1'b1, 1'b0, 13'h0ACE, 3'd2, 3'd5, 64'h0, 1'b1, 1'b1, "R8 stray during read");
    run(1'b0, 1'b1, 13'h01AB, 3'd0, 3'd6, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, "R6 stream write");
    for (int i = 0; i < 30; i++) begin
      logic rd, st;
      logic [2:0] len;
      logic [63:0] wd;
      st = ($urandom % 5) == 0;
      rd = st ? 1'b0 : 1'($urandom);
      len = 3'(($urandom % 4) + 1);
      wd = {$urandom, $urandom};
      run(rd, st, 13'($urandom), len, 3'(($urandom % 4) + 4), wd, 1'b1, 1'($urandom % 4 == 0),
          st ? "R6 random stream" : "R2 random access");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule